// File: doc/BRIEF.md
# Non-Power-of-Two Hashed Channel Address Rebuilder

This block takes a channel-normalized address and rebuilds the system address for a memory map that spreads traffic over 3, 5, 6, 10 or 12 channels with XOR address hashing. The target station is given by its ID and by the first station ID of the map. The block splits the difference into a group number and a position inside the group. It multiplies the upper address bits by the modulus (3 or 5) and adds the in-group position. It then opens the interleave gaps in the low bits and recomputes the hashed bits 8, 12 and 13 from the rebuilt address.

The seed for the bit-8 hash comes from one of two places. With a single socket it is a bit taken out of the normalized address at a configurable position. With two sockets it is the socket ID bit. All inputs are sampled on one clock edge and the result appears one cycle later. An unrecognized mode code gives a zero address with the error flag raised.

Top module: `np2_denorm`

## Requirements
- R1: A synchronous active-low reset clears `sys_addr_o` and `err_o`. Outputs are registered, so each result appears on the clock edge after its inputs are sampled.
- R2: Mode codes are 0 = 3 channels, 1 = 5 channels, 2 = 6 channels, 3 = 10 channels and 4 = 12 channels. The modulus is 3 for codes 0, 2 and 4 and 5 for codes 1 and 3. The offset is (station ID − base ID) modulo 2^ID_W. The group is offset / modulus and the in-group offset is offset % modulus.
- R3: When `multi_sock_i` = 0, the seed is `norm_addr_i[seed_pos_i]` and that bit is removed from the address used for the low part: bits above it move down by one. When `multi_sock_i` = 1, the seed is `sock_bit_i` and the address is used as it is.
- R4: Low part: a zero gap is opened at bit 8. For codes 2 and 3 a further one-bit gap is opened at bit 13. For code 4 a two-bit gap is opened at bit 12 instead. Only bits [13:0] are kept. Output bits [13:0] that are not hashed equal this low part.
- R5: High part: the original `norm_addr_i` is shifted right by `seed_pos_i` + 1 − `multi_sock_i`, multiplied by the modulus, increased by the in-group offset and placed from bit 14 upward, truncated to ADDR_W bits.
- R6: When the seed is 1, the in-group offset used in R5 is modulus − 1.
- R7: Output bit 8 = seed ^ a[14] ^ (a[16] & en64K) ^ (a[21] & en2M) ^ (a[30] & en1G), where a is the rebuilt address.
- R8: For codes 2, 3 and 4, output bit 13 = g ^ a[18]&en64K ^ a[23]&en2M ^ a[32]&en1G. Here g is group bit 1 for code 4 and group bit 0 otherwise.
- R9: For code 4 only, output bit 12 = group bit 0 ^ a[17]&en64K ^ a[22]&en2M ^ a[31]&en1G.
- R10: For codes 0 and 1, bits 12 and 13 are not hashed and come straight from the low part.
- R11: Mode codes 5, 6 and 7 set `err_o` = 1 and `sys_addr_o` = 0. Codes 0 to 4 give `err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| norm_addr_i | input | ADDR_W | Channel-normalized address |
| station_id_i | input | ID_W | Component ID of the target station |
| base_id_i | input | ID_W | First station component ID of the map |
| sock_bit_i | input | 1 | Socket ID bit, the seed when two sockets interleave |
| multi_sock_i | input | 1 | 1 when two sockets interleave |
| seed_pos_i | input | SH_W | Position of the hash seed bit in the normalized address |
| mode_i | input | 3 | Interleave mode code |
| hash64k_en_i | input | 1 | Enable for 64 KiB hash terms |
| hash2m_en_i | input | 1 | Enable for 2 MiB hash terms |
| hash1g_en_i | input | 1 | Enable for 1 GiB hash terms |
| sys_addr_o | output | ADDR_W | Rebuilt system address |
| err_o | output | 1 | Unrecognized mode |

## Verification
The case hardest to reach from the ports is a set seed that overrides an in-group offset that was already nonzero, together with a group number whose bit 1 changes the 12-channel bit-13 hash. Both depend on the address, the seed position and the station offset at the same time. The stimulus sweeps every offset from 0 to 14 for each mode, so groups 0 to 4 and every in-group position are covered. It uses several seed positions, one of them inside the low 14-bit window, and random addresses so that the seed takes both values. All eight combinations of hash enables are applied, with one and with two sockets.

// File: rtl/np2_pkg.sv
// Shared mode codes and mode decode helpers for the non-power-of-two
// address rebuilder. Assumes a 3-bit mode field.
package np2_pkg;

    typedef enum logic [2:0] {
        NP_CH3  = 3'd0,
        NP_CH5  = 3'd1,
        NP_CH6  = 3'd2,
        NP_CH10 = 3'd3,
        NP_CH12 = 3'd4
    } np_mode_e;

    // Recognized mode code
    function automatic logic np_known(input logic [2:0] m);
        return (m <= 3'd4);
    endfunction

    // Modes whose modulus is 5
    function automatic logic np_mod5(input logic [2:0] m);
        return (m == NP_CH5) || (m == NP_CH10);
    endfunction

    // Modes with a single extra gap at bit 13
    function automatic logic np_gap13(input logic [2:0] m);
        return (m == NP_CH6) || (m == NP_CH10);
    endfunction

    // Mode with a two-bit gap at bit 12
    function automatic logic np_gap12(input logic [2:0] m);
        return (m == NP_CH12);
    endfunction

endpackage

// File: rtl/np2_seed_split.sv
// Picks the hash seed bit and strips it from the address when a single
// socket is in use. Assumes seed_pos < ADDR_W.
module np2_seed_split #(
    parameter int ADDR_W = 52,
    parameter int SH_W   = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SH_W-1:0]   pos_i,
    input  logic              multi_i,
    input  logic              sock_bit_i,
    output logic              seed_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PW = SH_W + 1;

    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] above;
    logic [ADDR_W-1:0] at_pos;
    logic [PW-1:0]     pos_p1;

    // Select seed source and remove the seed bit for one socket
    always_comb begin
        pos_p1   = {1'b0, pos_i} + PW'(1);
        at_pos   = addr_i >> pos_i;
        low_mask = (ADDR_W'(1) << pos_i) - ADDR_W'(1);
        above    = (addr_i >> pos_p1) << pos_i;
        if (multi_i) begin
            seed_o = sock_bit_i;
            addr_o = addr_i;
        end else begin
            seed_o = at_pos[0];
            addr_o = (addr_i & low_mask) | above;
        end
    end

    // R3
    always_comb begin
        seed_src_chk: assert (multi_i || (addr_o[ADDR_W-1] == 1'b0))
            else $error("seed removal did not clear the top bit");
    end

endmodule

// File: rtl/np2_low_gap.sv
// Opens the interleave gaps in the low 14 bits for the selected mode.
// Assumes only bits [13:0] of the result are used.
module np2_low_gap #(
    parameter int ADDR_W = 52
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        mode_i,
    output logic [13:0]       low_o
);
    import np2_pkg::*;

    logic [13:0] g8;

    // Gap at bit 8, then mode-specific gap at 13 or at 13:12
    always_comb begin
        g8 = {addr_i[12:8], 1'b0, addr_i[7:0]};
        if (np_gap12(mode_i))
            low_o = {2'b00, g8[11:0]};
        else if (np_gap13(mode_i))
            low_o = {1'b0, g8[12:0]};
        else
            low_o = g8;
    end

    // R4
    always_comb begin
        gap_zero_chk: assert ((low_o[8] == 1'b0) &&
                              (!np_gap12(mode_i) || (low_o[13:12] == 2'b00)) &&
                              (!np_gap13(mode_i) || (low_o[13] == 1'b0)))
            else $error("interleave gap not clear");
    end

endmodule

// File: rtl/np2_group_div.sv
// Splits the station offset into group and in-group position for a
// modulus of 3 or 5 and applies the seed override. Assumes ID_W >= 3.
module np2_group_div #(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0] station_i,
    input  logic [ID_W-1:0] base_i,
    input  logic            mod5_i,
    input  logic            seed_i,
    output logic [ID_W-1:0] group_o,
    output logic [2:0]      goff_o
);
    logic [ID_W-1:0] off;
    logic [ID_W-1:0] q3, q5, r3, r5, rem;
    logic [2:0]      modm1;

    // Constant divides by 3 and 5, then select by modulus
    always_comb begin
        off   = station_i - base_i;
        q3    = off / ID_W'(3);
        q5    = off / ID_W'(5);
        r3    = off - q3 * ID_W'(3);
        r5    = off - q5 * ID_W'(5);
        group_o = mod5_i ? q5 : q3;
        rem     = mod5_i ? r5 : r3;
        modm1   = mod5_i ? 3'd4 : 3'd2;
        goff_o  = seed_i ? modm1 : rem[2:0];
    end

    // R2
    always_comb begin
        grp_rem_chk: assert (rem < (mod5_i ? ID_W'(5) : ID_W'(3)))
            else $error("in-group offset out of range");
    end

endmodule

// File: rtl/np2_hash_fix.sv
// Recomputes hashed bits 8, 12 and 13 of the rebuilt address.
// Assumes ADDR_W > 32 and that the hashed bit positions hold zero.
module np2_hash_fix #(
    parameter int ADDR_W = 52
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        mode_i,
    input  logic              seed_i,
    input  logic              grp0_i,
    input  logic              grp1_i,
    input  logic              en64k_i,
    input  logic              en2m_i,
    input  logic              en1g_i,
    output logic [ADDR_W-1:0] addr_o
);
    import np2_pkg::*;

    logic h8, h12, h13, gsel;

    // XOR fold of the hash terms per output bit
    always_comb begin
        h8   = seed_i ^ addr_i[14] ^ (addr_i[16] & en64k_i) ^
               (addr_i[21] & en2m_i) ^ (addr_i[30] & en1g_i);
        gsel = np_gap12(mode_i) ? grp1_i : grp0_i;
        h13  = gsel ^ (addr_i[18] & en64k_i) ^
               (addr_i[23] & en2m_i) ^ (addr_i[32] & en1g_i);
        h12  = grp0_i ^ (addr_i[17] & en64k_i) ^
               (addr_i[22] & en2m_i) ^ (addr_i[31] & en1g_i);
        addr_o    = addr_i;
        addr_o[8] = h8;
        if (np_gap12(mode_i) || np_gap13(mode_i))
            addr_o[13] = h13;
        if (np_gap12(mode_i))
            addr_o[12] = h12;
    end

    // R10
    always_comb begin
        pass_hi_chk: assert (np_gap12(mode_i) || np_gap13(mode_i) ||
                             (addr_o[13:12] == addr_i[13:12]))
            else $error("bits 13:12 altered in 3/5-channel mode");
    end

endmodule

// File: rtl/np2_denorm.sv
// Top of the non-power-of-two hashed address rebuilder. Combines seed
// selection, low gaps, group split, high-part scaling and hash repair,
// and registers the result. Assumes ADDR_W > 32, ID_W >= 3.
module np2_denorm #(
    parameter int ADDR_W = 52,
    parameter int ID_W   = 8,
    parameter int SH_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] norm_addr_i,
    input  logic [ID_W-1:0]   station_id_i,
    input  logic [ID_W-1:0]   base_id_i,
    input  logic              sock_bit_i,
    input  logic              multi_sock_i,
    input  logic [SH_W-1:0]   seed_pos_i,
    input  logic [2:0]        mode_i,
    input  logic              hash64k_en_i,
    input  logic              hash2m_en_i,
    input  logic              hash1g_en_i,
    output logic [ADDR_W-1:0] sys_addr_o,
    output logic              err_o
);
    import np2_pkg::*;

    localparam int PW     = SH_W + 1;
    localparam int LOW_W  = 14;

    logic              seed;
    logic [ADDR_W-1:0] stripped;
    logic [LOW_W-1:0]  low;
    logic [ID_W-1:0]   group;
    logic [2:0]        goff;
    logic [PW-1:0]     hi_pos;
    logic [ADDR_W-1:0] hi_src, hi_scaled, merged, hashed;
    logic              is_mod5;

    assign is_mod5 = np_mod5(mode_i);

    np2_seed_split #(.ADDR_W(ADDR_W), .SH_W(SH_W)) u_seed (
        .addr_i     (norm_addr_i),
        .pos_i      (seed_pos_i),
        .multi_i    (multi_sock_i),
        .sock_bit_i (sock_bit_i),
        .seed_o     (seed),
        .addr_o     (stripped)
    );

    np2_low_gap #(.ADDR_W(ADDR_W)) u_low (
        .addr_i (stripped),
        .mode_i (mode_i),
        .low_o  (low)
    );

    np2_group_div #(.ID_W(ID_W)) u_grp (
        .station_i (station_id_i),
        .base_i    (base_id_i),
        .mod5_i    (is_mod5),
        .seed_i    (seed),
        .group_o   (group),
        .goff_o    (goff)
    );

    // Scale the upper bits by the modulus with shift-and-add
    always_comb begin
        hi_pos = {1'b0, seed_pos_i} + PW'(1) - PW'(multi_sock_i);
        hi_src = norm_addr_i >> hi_pos;
        if (is_mod5)
            hi_scaled = (hi_src << 2) + hi_src + ADDR_W'(goff);
        else
            hi_scaled = (hi_src << 1) + hi_src + ADDR_W'(goff);
        merged = (hi_scaled << LOW_W) | ADDR_W'(low);
    end

    np2_hash_fix #(.ADDR_W(ADDR_W)) u_hash (
        .addr_i  (merged),
        .mode_i  (mode_i),
        .seed_i  (seed),
        .grp0_i  (group[0]),
        .grp1_i  (group[1]),
        .en64k_i (hash64k_en_i),
        .en2m_i  (hash2m_en_i),
        .en1g_i  (hash1g_en_i),
        .addr_o  (hashed)
    );

    // Output register with error gating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_addr_o <= '0;
            err_o      <= 1'b0;
        end else if (!np_known(mode_i)) begin
            sys_addr_o <= '0;
            err_o      <= 1'b1;
        end else begin
            sys_addr_o <= hashed;
            err_o      <= 1'b0;
        end
    end

    // R11
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !np_known(mode_i) |=> err_o);

    // R11
    good_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        np_known(mode_i) |=> !err_o);

    // R11
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (sys_addr_o == '0));

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!err_o && (sys_addr_o == '0)));

endmodule

// File: tb/sim_np2_denorm.sv
module sim_np2_denorm;
    localparam int AW = 52;
    localparam int IW = 8;
    localparam int SW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] na = '0;
    logic [IW-1:0] sid = '0, bid = '0;
    logic          sb = 1'b0, ms = 1'b0;
    logic [SW-1:0] sp = 6'd9;
    logic [2:0]    md = 3'd0;
    logic          e0 = 1'b0, e1 = 1'b0, e2 = 1'b0;
    logic [AW-1:0] sa;
    logic          er;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    np2_denorm #(.ADDR_W(AW), .ID_W(IW), .SH_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .norm_addr_i(na), .station_id_i(sid),
        .base_id_i(bid), .sock_bit_i(sb), .multi_sock_i(ms), .seed_pos_i(sp),
        .mode_i(md), .hash64k_en_i(e0), .hash2m_en_i(e1), .hash1g_en_i(e2),
        .sys_addr_o(sa), .err_o(er)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (mode %0d pos %0d multi %0d)",
                     tag, act, exp, md, sp, ms);
        end
    endtask

    // Expected system address from the requirements
    function automatic logic [63:0] model(input logic [63:0] a, input int s,
                                          input bit multi, input bit sbit,
                                          input int m, input int off,
                                          input bit h0, input bit h1, input bit h2);
        int mod, grp, go;
        bit seed;
        logic [63:0] arm, x, lo, hi, r;
        mod = (m == 1 || m == 3) ? 5 : 3;
        if (!multi) begin
            seed = a[s];
            arm  = (a & ((64'd1 << s) - 1)) | ((a >> (s + 1)) << s);
        end else begin
            seed = sbit;
            arm  = a;
        end
        x = ((arm >> 8) << 9) | (arm & 64'hff);
        if (m == 2 || m == 3) x = ((x >> 13) << 14) | (x & 64'h1fff);
        if (m == 4)           x = ((x >> 12) << 14) | (x & 64'hfff);
        lo  = x & 64'h3fff;
        grp = off / mod;
        go  = seed ? mod - 1 : off % mod;
        hi  = (a >> (s + 1 - int'(multi))) * mod + go;
        r   = (lo | (hi << 14)) & ((64'd1 << AW) - 1);
        r[8] = seed ^ r[14] ^ (r[16] & h0) ^ (r[21] & h1) ^ (r[30] & h2);
        if (m >= 2)
            r[13] = ((m == 4) ? grp[1] : grp[0]) ^ (r[18] & h0) ^ (r[23] & h1) ^ (r[32] & h2);
        if (m == 4)
            r[12] = grp[0] ^ (r[17] & h0) ^ (r[22] & h1) ^ (r[31] & h2);
        return r;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int poss[3];
        logic [63:0] exp;
        logic [63:0] nh;
        poss[0] = 9; poss[1] = 12; poss[2] = 16;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset addr", 64'(sa), 64'd0);
        chk("R1 reset err", 64'(er), 64'd0);
        rst_n = 1'b1;
        for (int m = 0; m < 8; m++) begin
            for (int mu = 0; mu < 2; mu++) begin
                for (int pi = 0; pi < 3; pi++) begin
                    for (int off = 0; off < 15; off++) begin
                        for (int en = 0; en < 8; en++) begin
                            md  = 3'(m);
                            ms  = mu[0];
                            sp  = SW'(poss[pi]);
                            na  = {$urandom, $urandom} & ((64'd1 << AW) - 1);
                            bid = IW'($urandom_range(0, 200));
                            sid = bid + IW'(off);
                            sb  = $urandom_range(0, 1) != 0;
                            {e2, e1, e0} = 3'(en);
                            @(negedge clk);
                            if (m > 4) begin
                                // R11 bad mode
                                chk("R11 err flag", 64'(er), 64'd1);
                                chk("R11 zero addr", 64'(sa), 64'd0);
                            end else begin
                                exp = model(64'(na), poss[pi], mu[0], sb, m, off, e0, e1, e2);
                                chk("R11 no err", 64'(er), 64'd0);
                                // R2 R5 R6 high part
                                chk("R2 R5 R6 high part", 64'(sa) >> 14, exp >> 14);
                                // R3 R4 R10 unhashed low bits
                                nh = (m == 4) ? 64'h0eff : ((m >= 2) ? 64'h1eff : 64'h3eff);
                                chk("R3 R4 R10 low bits", 64'(sa) & nh, exp & nh);
                                // R7 seed driven hash (R3 seed source)
                                chk("R7 bit8", 64'(sa[8]), 64'(exp[8]));
                                if (m >= 2) chk("R8 bit13", 64'(sa[13]), 64'(exp[13]));
                                if (m == 4) chk("R9 bit12", 64'(sa[12]), 64'(exp[12]));
                            end
                        end
                    end
                end
            end
        end
        // R1 reset again mid-run
        md = 3'd7;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears err", 64'(er), 64'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule